// File: doc/BRIEF.md
# Buffered input capture unit

This block timestamps transitions on a single input pin. A free-running up-counter advances on every clock. When the pin makes a transition of the selected kind, the counter value is stored in capture register A and a capture flag goes up. Optionally, each new capture first moves the older value of A into a second register C. Software can then read two consecutive timestamps and take their difference, which gives a pulse width or period.

Two control bits choose which transitions count. When the bits are equal they select one polarity. When they differ, both transitions count. The pin passes through a chain of synchronizer flops. A two-state level tracker, with states `LVL_LOW` and `LVL_HIGH`, compares the synchronized sample against the last level it recorded. The transition `LVL_LOW -> LVL_HIGH` marks a rising edge and the transition `LVL_HIGH -> LVL_LOW` marks a falling edge. In every other cycle the tracker stays in its state.

Software reaches all state through an 8-bit bus. The 16-bit counter, register A and register C are each split into a high byte and a low byte. A temporary byte register between the bus and these words makes every 16-bit transfer indivisible. The counter is also writable, so a test or a driver can preload it.

Top module: `bufcap_unit`

## Requirements
- R1: After reset, the counter, register A, register C, the control byte and both status flags are zero, so the unit captures falling edges only.
- R2: With control bit 0 (edge select A) = 0 and control bit 1 (edge select C) = 0, only falling pin transitions cause a capture.
- R3: With control bits 0 and 1 both = 1, only rising pin transitions cause a capture.
- R4: With control bits 0 and 1 unequal, both rising and falling pin transitions cause a capture.
- R5: Suppose a pin change is first sampled at clock edge n. Register A is then loaded at edge n+2 with the counter value held between edges n+1 and n+2. A capture has priority over a bus write to A in the same cycle.
- R6: With control bit 2 (buffered) = 1, each capture copies the old value of A into C in the same edge that reloads A. With bit 2 = 0, captures leave C unchanged.
- R7: A qualifying transition reloads A even when the capture flag is already set.
- R8: Status bit 0 (capture flag) is set by each capture. A write of 0 to that bit clears the flag only if a status read has returned it as 1 since the last status write. Otherwise the write, and any write of 1, leaves the flag as it was.
- R9: If a capture and a valid clear of the capture flag fall in the same cycle, the flag ends up set.
- R10: The counter adds one per clock, goes from 0xFFFF to 0x0000, and sets status bit 1 (overflow flag) on that wrap. A bus write to the counter overrides the increment. The overflow flag is cleared under the same read-then-write-0 rule as R8.
- R11: Bus addresses: 0/1 counter high/low, 2/3 A high/low, 4/5 C high/low, 6 control, 7 status. Reading a high byte returns it and, in the same cycle, copies the matching low byte into the temporary register. A following low-byte read returns the temporary register, even if the word has changed in between.
- R12: Writing a high-byte address only loads the temporary register. Writing the matching low-byte address then commits {temporary, written byte} to the 16-bit word in one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (see R11) |
| bus_wdata | input | DATA_W | Write byte |
| bus_rdata | output | DATA_W | Read byte, valid while a read is strobed |

## Verification
The bench builds the unit with DATA_W = 8, which gives a 16-bit counter, and with SYNC_STAGES = 2. This keeps the latency of R5 at a fixed three edges, so every expected timestamp follows from simple cycle counting. The small configuration allows a full sweep of all sixteen combinations of the two select bits, the buffer bit and the edge direction. Because the counter can be preloaded, its wrap point and the overflow flag come within a few cycles instead of 65536.

// File: rtl/bufcap_pkg.sv
package bufcap_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int ADDR_W = 3;
    localparam int CTRL_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAPA_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPA_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPC_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAPC_LO = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd7;

endpackage

// File: rtl/bufcap_edge.sv
module bufcap_edge
    import bufcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sel_a_i,
    input  logic sel_c_i,
    output logic cap_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    lvl_e                   state_q, state_d;
    logic                   rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign smp = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // transitions and edge outputs
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW:  if (smp)  begin state_d = LVL_HIGH; rise = 1'b1; end
            LVL_HIGH: if (!smp) begin state_d = LVL_LOW;  fall = 1'b1; end
        endcase
    end

    always_comb begin
        if (sel_a_i == sel_c_i) cap_o = sel_a_i ? rise : fall;
        else                    cap_o = rise | fall;
    end

    assert_cap_on_level_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> !$stable(state_q));
    assert_falling_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_o && !sel_a_i && !sel_c_i) |-> (state_q == LVL_HIGH));
    assert_rising_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_o && sel_a_i && sel_c_i) |-> (state_q == LVL_LOW));

endmodule

// File: rtl/bufcap_counter.sv
module bufcap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else             cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = !load_i && (cnt_o == TOP);

    assert_wrap_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_o == TOP) |=> (cnt_o == '0));
    assert_step_by_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_o == W'($past(cnt_o) + 1'b1)));

endmodule

// File: rtl/bufcap_capture.sv
module bufcap_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic         buf_en_i,
    input  logic [W-1:0] cnt_i,
    input  logic         wr_a_i,
    input  logic         wr_c_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] c_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      a_o <= '0;
        else if (cap_i)  a_o <= cnt_i;
        else if (wr_a_i) a_o <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  c_o <= '0;
        else if (cap_i && buf_en_i)  c_o <= a_o;
        else if (wr_c_i)             c_o <= wdata_i;
    end

    assert_latch_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (a_o == $past(cnt_i)));
    assert_buffer_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && buf_en_i) |=> (c_o == $past(a_o)));
    assert_c_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cap_i && buf_en_i) && !wr_c_i) |=> $stable(c_o));

endmodule

// File: rtl/bufcap_unit.sv
module bufcap_unit
    import bufcap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CNT_W = 2 * DATA_W;

    logic              rd, wr, is_hi;
    logic [DATA_W-1:0] temp_q, low_sel;
    logic [CNT_W-1:0]  word_w, cnt, reg_a, reg_c;
    logic [CTRL_W-1:0] ctrl_q;
    logic              cap_evt, cnt_wrap;
    logic              cap_flag, ovf_flag, arm_cap, arm_ovf;
    logic              stat_wr, stat_rd, clr_cap, clr_ovf;

    assign rd      = bus_sel && !bus_wr;
    assign wr      = bus_sel &&  bus_wr;
    assign is_hi   = (bus_addr == A_CNT_HI) || (bus_addr == A_CAPA_HI) || (bus_addr == A_CAPC_HI);
    assign word_w  = {temp_q, bus_wdata};
    assign stat_wr = wr && (bus_addr == A_STAT);
    assign stat_rd = rd && (bus_addr == A_STAT);
    assign clr_cap = stat_wr && !bus_wdata[0] && arm_cap;
    assign clr_ovf = stat_wr && !bus_wdata[1] && arm_ovf;

    bufcap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_pin),
        .sel_a_i(ctrl_q[0]), .sel_c_i(ctrl_q[1]), .cap_o(cap_evt)
    );

    bufcap_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_i(wr && (bus_addr == A_CNT_LO)), .load_val_i(word_w),
        .cnt_o(cnt), .wrap_o(cnt_wrap)
    );

    bufcap_capture #(.W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_evt), .buf_en_i(ctrl_q[2]),
        .cnt_i(cnt),
        .wr_a_i(wr && (bus_addr == A_CAPA_LO)),
        .wr_c_i(wr && (bus_addr == A_CAPC_LO)),
        .wdata_i(word_w), .a_o(reg_a), .c_o(reg_c)
    );

    always_comb begin
        unique case (bus_addr)
            A_CNT_HI:  low_sel = cnt[DATA_W-1:0];
            A_CAPA_HI: low_sel = reg_a[DATA_W-1:0];
            default:   low_sel = reg_c[DATA_W-1:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              temp_q <= '0;
        else if (rd && is_hi)    temp_q <= low_sel;
        else if (wr && is_hi)    temp_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (wr && bus_addr == A_CTRL)  ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_flag <= 1'b0;
            ovf_flag <= 1'b0;
            arm_cap  <= 1'b0;
            arm_ovf  <= 1'b0;
        end else begin
            if (cap_evt)       cap_flag <= 1'b1;
            else if (clr_cap)  cap_flag <= 1'b0;
            if (cnt_wrap)      ovf_flag <= 1'b1;
            else if (clr_ovf)  ovf_flag <= 1'b0;
            if (stat_wr) begin
                arm_cap <= 1'b0;
                arm_ovf <= 1'b0;
            end else if (stat_rd) begin
                if (cap_flag) arm_cap <= 1'b1;
                if (ovf_flag) arm_ovf <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (bus_addr)
                A_CNT_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
                A_CAPA_HI: bus_rdata = reg_a[CNT_W-1:DATA_W];
                A_CAPC_HI: bus_rdata = reg_c[CNT_W-1:DATA_W];
                A_CTRL:    bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                A_STAT:    bus_rdata = {{(DATA_W-2){1'b0}}, ovf_flag, cap_flag};
                default:   bus_rdata = temp_q;
            endcase
        end
    end

    assert_capture_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag);
    assert_no_blind_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !arm_cap) |=> cap_flag);
    assert_wrap_sets_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap |=> ovf_flag);
    assert_temp_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(temp_q));

endmodule

// File: tb/test_bufcap_unit.sv
`timescale 1ns/1ps
module test_bufcap_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0, errors = 0;
    int cyc = 0, cw = 0, cp = 0, rcyc = 0, rhi = 0, cnt_cw = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bufcap_unit #(.DATA_W(8), .SYNC_STAGES(2)) i_bufcap_unit (
        .clk(clk), .rst_n(rst_n), .cap_pin(pin), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; cw = cyc + 1;
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a; rcyc = cyc;
        #1 d = rdata;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] hi, input logic [15:0] v);
        bus_write(hi, v[15:8]);
        bus_write(hi + 3'd1, v[7:0]);
    endtask

    task automatic rd16(input logic [2:0] hi, output logic [15:0] v);
        logic [7:0] h, l;
        bus_read(hi, h);
        rhi = rcyc;
        bus_read(hi + 3'd1, l);
        v = {h, l};
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pin = v; cp = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [7:0]  d;
        logic [15:0] v, base, expa, expc, sa_v, sc_v;
        logic        qual;
        string       tag;

        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        bus_read(3'd6, d); check("R1 control", d, 0);
        bus_read(3'd7, d); check("R1 status", d, 0);
        rd16(3'd2, v);     check("R1 reg A", v, 0);
        rd16(3'd4, v);     check("R1 reg C", v, 0);

        // sweep: select A, select C, buffered, direction (1 = rising)
        for (int k = 0; k < 16; k++) begin
            logic sa, sc, bf, pol;
            sa = k[0]; sc = k[1]; bf = k[2]; pol = k[3];
            bus_write(3'd6, {5'b0, bf, sc, sa});
            set_pin(!pol);
            idle(6);
            sa_v = 16'hA000 | 16'(k);
            sc_v = 16'hC000 | 16'(k);
            wr16(3'd2, sa_v);
            wr16(3'd4, sc_v);
            bus_read(3'd7, d);
            bus_write(3'd7, 8'h00);
            base = 16'h0100 + 16'(k) * 16'h0F00;
            wr16(3'd0, base);
            cnt_cw = cw;
            set_pin(pol);
            idle(6);
            qual = (sa == sc) ? (sa ? pol : !pol) : 1'b1;
            tag  = (sa == sc) ? (sa ? "R3" : "R2") : "R4";
            expa = qual ? 16'(base + 16'(cp + 2 - cnt_cw)) : sa_v;
            expc = (qual && bf) ? sa_v : sc_v;
            rd16(3'd2, v);     check({tag, "/R5 reg A"}, v, expa);
            rd16(3'd4, v);     check("R6 reg C", v, expc);
            bus_read(3'd7, d); check("R8 capture flag", d[0], qual);
        end

        // both edges, unbuffered
        bus_write(3'd6, 8'h01);

        // R12: byte writes
        wr16(3'd2, 16'h5A3C);
        rd16(3'd2, v);       check("R12 full write", v, 16'h5A3C);
        bus_write(3'd2, 8'hFF);
        rd16(3'd2, v);       check("R12 high alone no commit", v, 16'h5A3C);

        // R11: low byte comes from the snapshot taken at the high read
        wr16(3'd0, 16'h2000);
        cnt_cw = cw;
        set_pin(!pin);
        bus_read(3'd2, d);   check("R11 high byte", d, 8'h5A);
        idle(6);
        bus_read(3'd3, d);   check("R11 low from temp", d, 8'h3C);
        rd16(3'd2, v);       check("R11/R5 new word", v, 16'(16'h2000 + 16'(cp + 2 - cnt_cw)));

        // R8 / R9 / R7: flag protocol
        bus_read(3'd7, d);
        bus_write(3'd7, 8'h00);
        set_pin(!pin);
        idle(6);
        bus_write(3'd7, 8'h00);
        bus_read(3'd7, d);   check("R8 write without read keeps flag", d[0], 1);
        set_pin(!pin);
        @(negedge clk);
        bus_write(3'd7, 8'h00);
        idle(4);
        bus_write(3'd7, 8'h00);
        bus_read(3'd7, d);   check("R9 capture beats clear", d[0], 1);
        rd16(3'd2, v);       check("R7 capture with flag set", v, 16'(16'h2000 + 16'(cp + 2 - cnt_cw)));
        bus_write(3'd7, 8'h01);
        bus_read(3'd7, d);   check("R8 write of one no effect", d[0], 1);
        bus_write(3'd7, 8'h00);
        bus_read(3'd7, d);   check("R8 armed clear", d[0], 0);

        // R10: counter and overflow
        check("R10 no overflow yet", d[1], 0);
        wr16(3'd0, 16'h12F0);
        cnt_cw = cw;
        idle(5);
        rd16(3'd0, v);       check("R10 count", v, 16'(16'h12F0 + 16'(rhi - cnt_cw)));
        wr16(3'd0, 16'hFFFE);
        cnt_cw = cw;
        idle(6);
        rd16(3'd0, v);       check("R10 wrapped count", v, 16'(16'hFFFE + 16'(rhi - cnt_cw)));
        bus_read(3'd7, d);   check("R10 overflow flag", d[1], 1);
        bus_write(3'd7, 8'h00);
        bus_read(3'd7, d);   check("R10 overflow cleared", d[1], 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule